// File: doc/BRIEF.md
# JTAG Daisy-Chain Configuration Sequencer

This block is a JTAG master that loads configuration data into a chain of programmable devices that share TCK and TMS and are daisy-chained from TDI to TDO. It handles one target at a time. It first forces every TAP into Test-Logic-Reset. It then walks the TAPs to Shift-IR and shifts one chained instruction scan, which leaves the load opcode in the target and the bypass opcode in every other device. After a pass through Run-Test/Idle it enters Shift-DR and serialises that device's configuration words. It moves on to the next device index until all are loaded.

When all devices are loaded, the sequencer resets the TAPs again and broadcasts a start-up opcode to every device. It then idles the chain for a fixed number of TCK cycles and signals completion. When reconfiguration is requested at start, each data scan is prefixed with a fixed five-word shutdown preamble that resynchronises the target and clears its CRC. Configuration words arrive on a valid/ready stream and are consumed only when the serialiser has room. TCK is divided down from the system clock.

Top module: `jtag_chain_loader`

## Requirements
- R1: After an accepted start, the first 5 TCK rising edges see TMS high, which leaves the chain in Test-Logic-Reset.
- R2: Each instruction scan is NUM_DEV*IR_LEN bits long. Device NUM_DEV-1 (nearest TDO) is sent first and device 0 last, and each opcode goes LSB first. The target holds LOAD_OP and every other device holds BYPASS_OP.
- R3: Between the Update-IR of a load scan and the following Capture-DR, the TAP spends at least one TCK cycle in Run-Test/Idle.
- R4: Devices are loaded one at a time in index order 0..NUM_DEV-1, where device 0 is nearest TDI. Each load is one instruction scan followed by exactly one data scan.
- R5: A data scan for target d sends its WORDS_PER_DEV stream words in arrival order, each MSB first, then d zero bits for the bypass registers between TDI and the target. TMS is high only on the last shifted bit.
- R6: If `reconfig` is high when start is accepted, every data scan begins with 0xFFFFFFFF, 0xAA995566, 0x30008001, 0x00000007, 0x00000000 (each MSB first) ahead of the stream words. If it is low, these words are absent.
- R7: After the last device's data scan, the chain passes through Test-Logic-Reset again. The next instruction scan then places START_OP in every device.
- R8: After the start-up Update-IR, exactly 12 TCK rising edges occur with the TAP in Run-Test/Idle. Then busy falls, done rises and TCK stays low.
- R9: TMS and TDI change only while TCK is low, together with its falling edge. With no stall, every TCK phase lasts HALF_DIV system clocks.
- R10: `cfg_ready` is high only while the serialiser is empty and still owes stream words to the current scan. Exactly NUM_DEV*WORDS_PER_DEV words are accepted per run. While a needed word is missing, TCK holds high instead of falling.
- R11: A start pulse while busy has no effect on the sequence in progress.
- R12: Under reset: busy=0, done=0, tck=0, tms=1, cfg_ready=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that begins a configuration run when idle |
| reconfig | input | 1 | Prefix each data scan with the shutdown preamble (sampled at start) |
| cfg_valid | input | 1 | Configuration word valid |
| cfg_ready | output | 1 | Serialiser requests the next word |
| cfg_data | input | 32 | Configuration word |
| tck | output | 1 | JTAG test clock |
| tms | output | 1 | JTAG mode select |
| tdi | output | 1 | JTAG serial data to the chain |
| busy | output | 1 | High for the whole run |
| done | output | 1 | High after a run completes, until the next start |

## Verification
The bench models the TAP state machine from the TCK/TMS/TDI pins and captures every instruction and data scan. It compares them bit for bit with scans built from the requirements. This catches a chain concatenated in the wrong order, which would put the load opcode in the mirror-image device, and a missing or misplaced bypass pad, which would leave the target's data shifted by one bit per device. Irregular stream gaps test the TCK stall: a design that let TCK fall without a word would shift garbage bits, and one that raised ready early would swallow extra words. An off-by-one idle count, a preamble leaking into a plain load, and a second start pulse that restarts the sequence each show up as a wrong idle-edge count, a wrong scan length, or an extra instruction scan.

// File: rtl/jcl_pkg.sv
package jcl_pkg;

    localparam int WORD_W    = 32;
    localparam int PRE_WORDS = 5;
    localparam int RST_TCKS  = 5;
    localparam int IDLE_TCKS = 12;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RST,
        ST_TO_RTI,
        ST_TO_SIR,
        ST_SIR,
        ST_UPD_IR,
        ST_TO_SDR,
        ST_SDR,
        ST_UPD_DR,
        ST_RUNIDLE,
        ST_END
    } seq_state_e;

    typedef struct packed {
        logic tms;
        logic tdi;
    } pin_pair_t;

    // Fixed shutdown/resync words sent ahead of the data when reconfiguring.
    function automatic logic [WORD_W-1:0] preamble_word(input int unsigned idx);
        case (idx)
            0:       return 32'hFFFF_FFFF;
            1:       return 32'hAA99_5566;
            2:       return 32'h3000_8001;
            3:       return 32'h0000_0007;
            default: return 32'h0000_0000;
        endcase
    endfunction

    // Bit at scan position pos of the chained instruction scan.
    // Position 0 is shifted first and lands in the device nearest TDO.
    function automatic logic chain_ir_bit(
        input int unsigned pos,
        input int unsigned ir_len,
        input int unsigned ndev,
        input int unsigned target,
        input logic        startup,
        input logic [31:0] ld_op,
        input logic [31:0] bp_op,
        input logic [31:0] su_op
    );
        int unsigned dev_i;
        int unsigned bit_i;
        logic [31:0] op;
        dev_i = ndev - 1 - (pos / ir_len);
        bit_i = pos % ir_len;
        op    = startup ? su_op : ((dev_i == target) ? ld_op : bp_op);
        return op[bit_i[4:0]];
    endfunction

endpackage

// File: rtl/jcl_tck_div.sv
module jcl_tck_div #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic hold,
    output logic tck,
    output logic fall_tick
);
    localparam int CNTW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CNTW-1:0] CNT_TOP = CNTW'(HALF_DIV - 1);

    logic [CNTW-1:0] cnt_q;
    logic            tck_q;
    logic            at_top;

    assign at_top    = (cnt_q == CNT_TOP);
    assign fall_tick = run && tck_q && at_top && !hold;
    assign tck       = tck_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
            tck_q <= 1'b0;
        end else if (at_top) begin
            if (!(tck_q && hold)) begin
                cnt_q <= '0;
                tck_q <= ~tck_q;
            end
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R10: a held high phase never falls while the data bit is missing
    a_r10_hold_high: assert property (@(posedge clk) disable iff (rst)
        (run && tck_q && at_top && hold) |=> tck_q);

endmodule

// File: rtl/jcl_word_ser.sv
module jcl_word_ser #(
    parameter int WORDS_PER_DEV = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        use_pre,
    input  logic        take,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [31:0] in_data,
    output logic        bit_o,
    output logic        bit_ok
);
    import jcl_pkg::*;

    localparam int WCW = $clog2(PRE_WORDS + WORDS_PER_DEV + 1);
    localparam int LW  = $clog2(WORD_W + 1);

    logic [WORD_W-1:0] sh_q;
    logic [LW-1:0]     left_q;
    logic [WCW-1:0]    wcnt_q;
    logic [WCW-1:0]    total;
    logic              need;
    logic              from_pre;
    logic              load;

    assign total    = use_pre ? WCW'(PRE_WORDS + WORDS_PER_DEV) : WCW'(WORDS_PER_DEV);
    assign need     = !clr && (left_q == '0) && (wcnt_q < total);
    assign from_pre = use_pre && (wcnt_q < WCW'(PRE_WORDS));
    assign in_ready = need && !from_pre;
    assign load     = need && (from_pre || in_valid);
    assign bit_o    = sh_q[WORD_W-1];
    assign bit_ok   = (left_q != '0);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sh_q   <= '0;
            left_q <= '0;
            wcnt_q <= '0;
        end else if (load) begin
            sh_q   <= from_pre ? preamble_word(32'(wcnt_q)) : in_data;
            left_q <= LW'(WORD_W);
            wcnt_q <= wcnt_q + 1'b1;
        end else if (take && bit_ok) begin
            sh_q   <= {sh_q[WORD_W-2:0], 1'b0};
            left_q <= left_q - 1'b1;
        end
    end

    // R5: an accepted stream word is presented MSB first on the next cycle
    a_r5_msb_first: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (bit_ok && (bit_o == $past(in_data[WORD_W-1]))));

endmodule

// File: rtl/jtag_chain_loader.sv
module jtag_chain_loader #(
    parameter int              NUM_DEV       = 3,
    parameter int              IR_LEN        = 6,
    parameter int              WORDS_PER_DEV = 4,
    parameter int              HALF_DIV      = 2,
    parameter logic [IR_LEN-1:0] LOAD_OP     = 'h05,
    parameter logic [IR_LEN-1:0] BYPASS_OP   = '1,
    parameter logic [IR_LEN-1:0] START_OP    = 'h0C
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        reconfig,
    input  logic        cfg_valid,
    output logic        cfg_ready,
    input  logic [31:0] cfg_data,
    output logic        tck,
    output logic        tms,
    output logic        tdi,
    output logic        busy,
    output logic        done
);
    import jcl_pkg::*;

    localparam int IR_TOT   = NUM_DEV * IR_LEN;
    localparam int BITS_PL  = WORDS_PER_DEV * WORD_W;
    localparam int BITS_PRE = (PRE_WORDS + WORDS_PER_DEV) * WORD_W;
    localparam int SCAN_MAX = BITS_PRE + NUM_DEV + IR_TOT + IDLE_TCKS;
    localparam int CW       = $clog2(SCAN_MAX + 1);
    localparam int DW       = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

    seq_state_e  st_q, st_nx;
    logic [CW-1:0] step_q, step_nx;
    logic [DW-1:0] dev_q, dev_nx;
    logic        fin_q, fin_nx;
    logic        busy_q, done_q, kick_q, pre_q;
    pin_pair_t   pins_q, pins_nx;
    logic        take;
    logic        emit;
    logic        fall_tick;
    logic        hold;
    logic        ser_bit, ser_ok, ser_clr;
    logic [CW-1:0] data_bits, scan_len;

    assign data_bits = pre_q ? CW'(BITS_PRE) : CW'(BITS_PL);
    assign scan_len  = data_bits + CW'(dev_q);
    assign emit      = kick_q || fall_tick;
    assign hold      = (st_q == ST_SDR) && (step_q < data_bits) && !ser_ok;
    assign ser_clr   = !((st_q == ST_TO_SDR) || (st_q == ST_SDR));

    jcl_tck_div #(.HALF_DIV(HALF_DIV)) u_div (
        .clk       (clk),
        .rst       (rst),
        .run       (busy_q && !kick_q),
        .hold      (hold),
        .tck       (tck),
        .fall_tick (fall_tick)
    );

    jcl_word_ser #(.WORDS_PER_DEV(WORDS_PER_DEV)) u_ser (
        .clk      (clk),
        .rst      (rst),
        .clr      (ser_clr),
        .use_pre  (pre_q),
        .take     (take),
        .in_valid (cfg_valid),
        .in_ready (cfg_ready),
        .in_data  (cfg_data),
        .bit_o    (ser_bit),
        .bit_ok   (ser_ok)
    );

    // Pin values for the TCK cycle that starts at this emit event.
    always_comb begin
        pins_nx = '{tms: 1'b0, tdi: 1'b0};
        st_nx   = st_q;
        step_nx = step_q + 1'b1;
        dev_nx  = dev_q;
        fin_nx  = fin_q;
        take    = 1'b0;
        case (st_q)
            ST_RST: begin
                pins_nx.tms = 1'b1;
                if (step_q == CW'(RST_TCKS - 1)) begin
                    st_nx = ST_TO_RTI; step_nx = '0;
                end
            end
            ST_TO_RTI: begin
                st_nx = ST_TO_SIR; step_nx = '0;
            end
            ST_TO_SIR: begin
                pins_nx.tms = (step_q < CW'(2));
                if (step_q == CW'(3)) begin
                    st_nx = ST_SIR; step_nx = '0;
                end
            end
            ST_SIR: begin
                pins_nx.tdi = chain_ir_bit(32'(step_q), IR_LEN, NUM_DEV, 32'(dev_q), fin_q,
                                           32'(LOAD_OP), 32'(BYPASS_OP), 32'(START_OP));
                pins_nx.tms = (step_q == CW'(IR_TOT - 1));
                if (step_q == CW'(IR_TOT - 1)) begin
                    st_nx = ST_UPD_IR; step_nx = '0;
                end
            end
            ST_UPD_IR: begin
                pins_nx.tms = (step_q == '0);
                if (step_q == CW'(1)) begin
                    step_nx = '0;
                    st_nx   = fin_q ? ST_RUNIDLE : ST_TO_SDR;
                end
            end
            ST_TO_SDR: begin
                pins_nx.tms = (step_q == '0);
                if (step_q == CW'(2)) begin
                    st_nx = ST_SDR; step_nx = '0;
                end
            end
            ST_SDR: begin
                if (step_q < data_bits) begin
                    pins_nx.tdi = ser_bit;
                    take        = emit;
                end
                pins_nx.tms = (step_q == scan_len - 1'b1);
                if (step_q == scan_len - 1'b1) begin
                    st_nx = ST_UPD_DR; step_nx = '0;
                end
            end
            ST_UPD_DR: begin
                pins_nx.tms = (step_q == '0);
                if (step_q == CW'(1)) begin
                    step_nx = '0;
                    if (dev_q == DW'(NUM_DEV - 1)) begin
                        st_nx  = ST_RST;
                        fin_nx = 1'b1;
                    end else begin
                        dev_nx = dev_q + 1'b1;
                        st_nx  = ST_TO_SIR;
                    end
                end
            end
            ST_RUNIDLE: begin
                if (step_q == CW'(IDLE_TCKS - 1)) begin
                    st_nx = ST_END; step_nx = '0;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            step_q <= '0;
            dev_q  <= '0;
            fin_q  <= 1'b0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
            kick_q <= 1'b0;
            pre_q  <= 1'b0;
            pins_q <= '{tms: 1'b1, tdi: 1'b0};
        end else begin
            kick_q <= 1'b0;
            if (st_q == ST_IDLE) begin
                if (start) begin
                    st_q   <= ST_RST;
                    step_q <= '0;
                    dev_q  <= '0;
                    fin_q  <= 1'b0;
                    busy_q <= 1'b1;
                    done_q <= 1'b0;
                    kick_q <= 1'b1;
                    pre_q  <= reconfig;
                end
            end else if (emit) begin
                if (st_q == ST_END) begin
                    st_q   <= ST_IDLE;
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    pins_q <= pins_nx;
                    st_q   <= st_nx;
                    step_q <= step_nx;
                    dev_q  <= dev_nx;
                    fin_q  <= fin_nx;
                end
            end
        end
    end

    assign tms  = pins_q.tms;
    assign tdi  = pins_q.tdi;
    assign busy = busy_q;
    assign done = done_q;

    // R9: pins move only while TCK is low
    a_r9_pins_on_low: assert property (@(posedge clk) disable iff (rst)
        (!$stable(tms) || !$stable(tdi)) |-> !tck);

    // R12: TCK parked low whenever the sequencer is idle
    a_r12_tck_idle_low: assert property (@(posedge clk) disable iff (rst)
        !busy_q |-> !tck);

    // R11: a start pulse during a run does not end or restart it
    a_r11_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy_q && start && !emit) |=> (busy_q && $stable(dev_q) && $stable(st_q)));

    // R8: the run ends only from the final idle phase, with done raised
    a_r8_done_at_end: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_q) |-> (done_q && ($past(st_q) == ST_END)));

    // R5: a data bit is never shifted out before the serialiser holds it
    a_r5_bit_ready: assert property (@(posedge clk) disable iff (rst)
        (emit && (st_q == ST_SDR) && (step_q < data_bits)) |-> ser_ok);

endmodule

// File: tb/sim_jtag_chain_loader.sv
module sim_jtag_chain_loader;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_DEV    = 3;
    localparam int IR_LEN     = 6;
    localparam int W          = 4;
    localparam int HALF       = 2;
    localparam logic [IR_LEN-1:0] LD = 6'h05;
    localparam logic [IR_LEN-1:0] BP = 6'h3F;
    localparam logic [IR_LEN-1:0] SU = 6'h0C;
    localparam int NWORDS     = NUM_DEV * W;

    typedef enum int {TLR, RTI, SDS, CDR, SDR, E1D, PDR, E2D, UDR,
                      SIS, CIR, SIR, E1I, PIR, E2I, UIR} tap_e;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic reconfig = 1'b0;
    logic cfg_valid = 1'b0;
    logic [31:0] cfg_data = '0;
    logic cfg_ready, tck, tms, tdi, busy, done;

    always #(CLK_PERIOD / 2) clk = ~clk;

    jtag_chain_loader #(
        .NUM_DEV(NUM_DEV), .IR_LEN(IR_LEN), .WORDS_PER_DEV(W), .HALF_DIV(HALF),
        .LOAD_OP(LD), .BYPASS_OP(BP), .START_OP(SU)
    ) u0 (
        .clk(clk), .rst(rst), .start(start), .reconfig(reconfig),
        .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_data(cfg_data),
        .tck(tck), .tms(tms), .tdi(tdi), .busy(busy), .done(done)
    );

    int checks = 0;
    int errors = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    logic [31:0] words [NWORDS];
    bit   run_pre;
    bit   full_mode;

    // ---------------- expected-value functions ----------------
    function automatic logic [31:0] pre_w(input int i);
        case (i)
            0: return 32'hFFFFFFFF;
            1: return 32'hAA995566;
            2: return 32'h30008001;
            3: return 32'h00000007;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic exp_ir_bit(input int k, input int i);
        int dv;
        logic [IR_LEN-1:0] op;
        dv = NUM_DEV - 1 - i / IR_LEN;
        op = (k == NUM_DEV) ? SU : ((dv == k) ? LD : BP);
        return op[i % IR_LEN];
    endfunction

    function automatic int exp_dr_len(input int d);
        return (run_pre ? 5 * 32 : 0) + W * 32 + d;
    endfunction

    function automatic logic exp_dr_bit(input int d, input int j);
        int pb;
        logic [31:0] wv;
        pb = run_pre ? 5 * 32 : 0;
        if (j < pb) begin
            wv = pre_w(j / 32);
            return wv[31 - j % 32];
        end else if (j < pb + W * 32) begin
            wv = words[d * W + (j - pb) / 32];
            return wv[31 - (j - pb) % 32];
        end
        return 1'b0;
    endfunction

    function automatic tap_e tap_next(input tap_e s, input logic m);
        case (s)
            TLR: return m ? TLR : RTI;
            RTI: return m ? SDS : RTI;
            SDS: return m ? SIS : CDR;
            CDR: return m ? E1D : SDR;
            SDR: return m ? E1D : SDR;
            E1D: return m ? UDR : PDR;
            PDR: return m ? E2D : PDR;
            E2D: return m ? UDR : SDR;
            UDR: return m ? SDS : RTI;
            SIS: return m ? TLR : CIR;
            CIR: return m ? E1I : SIR;
            SIR: return m ? E1I : SIR;
            E1I: return m ? UIR : PIR;
            PIR: return m ? E2I : PIR;
            E2I: return m ? UIR : SIR;
            default: return m ? SDS : RTI;
        endcase
    endfunction

    // ---------------- chain monitor ----------------
    tap_e ts = TLR;
    logic ir_buf [64];
    logic dr_buf [1024];
    int ir_n, dr_n, ir_k, dr_k;
    int rise_idx, r1_bad, idle_rises, rti_bad, pin_viol, irregular, short_ph, run_len;
    bit r1_tlr, rti_seen, after_last, saw_tlr2, su_loaded, have_edge;
    logic p_tck = 1'b0, p_tms = 1'b1, p_tdi = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if ((tms !== p_tms || tdi !== p_tdi) && tck) pin_viol++;
            run_len++;
            if (tck !== p_tck) begin
                if (have_edge) begin
                    if (run_len != HALF) irregular++;
                    if (run_len < HALF) short_ph++;
                end
                have_edge = 1;
                run_len   = 0;
            end
            if (tck && !p_tck) begin
                tap_e nx;
                int bad;
                rise_idx++;
                if (rise_idx <= 5 && !tms) r1_bad++;
                if (after_last && ts == TLR) saw_tlr2 = 1;
                if (su_loaded && ts == RTI) idle_rises++;
                if (ts == SIR && ir_n < 64) begin ir_buf[ir_n] = tdi; ir_n++; end
                if (ts == SDR && dr_n < 1024) begin dr_buf[dr_n] = tdi; dr_n++; end
                if (ts == RTI) rti_seen = 1;
                nx = tap_next(ts, tms);
                if (rise_idx == 5 && nx == TLR) r1_tlr = 1;
                if (nx == UIR) begin
                    check(ir_n == NUM_DEV * IR_LEN, "R2 instruction scan length", ir_n, NUM_DEV * IR_LEN);
                    bad = 0;
                    for (int i = 0; i < NUM_DEV * IR_LEN; i++)
                        if (i < ir_n && ir_buf[i] !== exp_ir_bit(ir_k, i)) bad++;
                    if (ir_k == NUM_DEV) begin
                        check(saw_tlr2, "R7 reset before start-up scan", saw_tlr2, 1);
                        check(bad == 0, "R7 start-up opcode bits wrong", bad, 0);
                        su_loaded = 1;
                    end else begin
                        check(bad == 0, "R2 load/bypass opcode bits wrong", bad, 0);
                    end
                    ir_k++;
                    ir_n = 0;
                    rti_seen = 0;
                end
                if (nx == CDR && !rti_seen) rti_bad++;
                if (nx == UDR) begin
                    check(dr_n == exp_dr_len(dr_k), "R5/R6 data scan length", dr_n, exp_dr_len(dr_k));
                    bad = 0;
                    for (int j = 0; j < exp_dr_len(dr_k); j++)
                        if (j < dr_n && dr_buf[j] !== exp_dr_bit(dr_k, j)) bad++;
                    check(bad == 0, run_pre ? "R6 preamble+data bits wrong" : "R5 data bits wrong", bad, 0);
                    dr_k++;
                    dr_n = 0;
                    if (dr_k == NUM_DEV) after_last = 1;
                end
                ts = nx;
            end
        end
        p_tck = tck; p_tms = tms; p_tdi = tdi;
    end

    // ---------------- stream driver ----------------
    int  sidx = 0;
    bit  hs_pend = 0;

    always @(negedge clk) begin
        if (hs_pend) sidx++;
        cfg_valid = (sidx < NWORDS) && (full_mode || ($urandom % 4 != 0));
        cfg_data  = (sidx < NWORDS) ? words[sidx] : 32'hDEAD_BEEF;
        hs_pend   = cfg_valid && cfg_ready;
    end

    // ---------------- stimulus ----------------
    task automatic begin_run(input bit pre, input bit full);
        @(posedge clk);
        for (int i = 0; i < NWORDS; i++) words[i] = $urandom;
        run_pre = pre; full_mode = full;
        sidx = 0; hs_pend = 0;
        ir_n = 0; dr_n = 0; ir_k = 0; dr_k = 0;
        rise_idx = 0; r1_bad = 0; idle_rises = 0; rti_bad = 0;
        pin_viol = 0; irregular = 0; short_ph = 0; run_len = 0;
        r1_tlr = 0; rti_seen = 0; after_last = 0; saw_tlr2 = 0; su_loaded = 0; have_edge = 0;
        @(negedge clk);
        reconfig = pre;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic finish_run(input bit full);
        int n = 0;
        while (!done && n < 60000) begin @(negedge clk); n++; end
        check(done == 1'b1, "R8 run completes", done, 1);
        repeat (4 * HALF + 4) @(negedge clk);
        check(r1_bad == 0 && r1_tlr, "R1 five TMS-high edges reach reset", r1_bad, 0);
        check(ir_k == NUM_DEV + 1, "R4/R11 instruction scan count", ir_k, NUM_DEV + 1);
        check(dr_k == NUM_DEV, "R4 data scan count", dr_k, NUM_DEV);
        check(rti_bad == 0, "R3 idle visit before data scan", rti_bad, 0);
        check(idle_rises == 12, "R8 idle edges after start-up", idle_rises, 12);
        check(busy == 0 && done == 1 && tck == 0, "R8 end state", {busy, done, tck}, 3'b010);
        check(pin_viol == 0, "R9 pins change with TCK low", pin_viol, 0);
        if (full) check(irregular == 0, "R9 TCK phase equals divider", irregular, 0);
        else      check(short_ph == 0, "R9 no TCK phase shorter than divider", short_ph, 0);
        check(sidx == NWORDS, "R10 words accepted", sidx, NWORDS);
        check(cfg_ready == 0, "R10 ready low when idle", cfg_ready, 0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check(busy == 0 && done == 0 && tck == 0 && tms == 1 && cfg_ready == 0,
              "R12 reset state", {busy, done, tck, tms, cfg_ready}, 5'b00010);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // run 1: plain load, stream always valid
        begin_run(1'b0, 1'b1);
        finish_run(1'b1);

        // run 2: reconfiguration preamble, random stream gaps
        begin_run(1'b1, 1'b0);
        finish_run(1'b0);

        // run 3: plain load, random gaps, stray start while busy
        begin_run(1'b0, 1'b0);
        repeat (300) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R11 busy kept after stray start", busy, 1);
        finish_run(1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule